// File: doc/BRIEF.md
# SPI Flash Identification and Status Responder

This block is the serial slave front end of a NOR flash model that answers only the identification and status commands. It works in SPI mode 0, most significant bit first. A host drives serial clock, chip select (active low) and the host-to-device data line. The block samples all three in its own clock domain, assembles the opcode and any following bytes, and returns response bytes on the device-to-host line. The manufacturer, memory type and device identifiers are parameters.

A status register holds a write-enable latch in bit 1 and six writable bits in 7:2. Bit 0 reads as zero. The block does not model the memory array. Any opcode it does not answer is consumed byte by byte until chip select rises, and the data line is never driven for it. The pad tristate is controlled through a separate enable output.

Top module: `spi_flash_id_resp`

## Requirements
- R1: After reset, miso_oe_o is low and a status read returns 0x00.
- R2: In mode 0, host data is sampled on rising SCLK and shifted MSB first. miso_o and miso_oe_o change only after a falling SCLK edge or a chip select change.
- R3: Opcode 0x9F returns MFR_ID, then MEM_TYPE, then DEV_ID. Any later bytes in the same transaction are not driven.
- R4: Opcode 0x90 takes two dummy bytes and a selector byte. A selector of 0x01 returns DEV_ID then MFR_ID; any other selector returns MFR_ID then DEV_ID.
- R5: Opcode 0xAB takes three dummy bytes and then returns DEV_ID.
- R6: Opcode 0x05 returns the status byte on every following byte for as long as chip select stays low. Bit 1 is write enable and bit 0 is always 0.
- R7: Opcode 0x06 sets status bit 1 once the opcode byte completes. Opcode 0x04 clears it.
- R8: Opcode 0x01 with write enable set, closed by chip select rising after exactly one or two complete data bytes, loads bits 7:2 from the first data byte and clears bit 1. A second data byte has no effect.
- R9: An 0x01 transaction is discarded with no status change if chip select rises mid-byte, after more than two data bytes, or while write enable is clear.
- R10: miso_oe_o is high only during response bytes. It stays low for the opcode, dummy and selector bytes, for unanswered opcodes, and while chip select is high.
- R11: Chip select rising at any point resets the bit count and the command state, so the next transaction decodes a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Host-to-device data |
| miso_o | output | 1 | Device-to-host data |
| miso_oe_o | output | 1 | Output enable for the miso pad |

## Verification
The checker assumes that every serial input is asynchronous to clk_i but slow: each SCLK phase, and the gap between a chip select change and the nearest SCLK edge, must last longer than SYNC_STAGES plus two clock cycles. Under that assumption no rising and falling event can collide in the same sampled cycle. The checker also assumes SCLK is low whenever chip select changes, as mode 0 requires. The bench drives every line from the falling clock edge, holds each SCLK phase for eight clock cycles, and waits several phases around each chip select change. It never pulses SCLK while chip select is high.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_REMS = 8'h90;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] SEL_DEV_FIRST = 8'h01;

  typedef struct packed {
    logic       vld;
    logic [7:0] data;
  } resp_t;
endpackage

// File: rtl/spi_id_sync.sv
module spi_id_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic cs_end_o,
  output logic mosi_o
);
  localparam logic [2:0] RST_V = 3'b100; // {cs, sclk, mosi}

  logic [STAGES-1:0][2:0] pipe_q;
  logic [2:0] st;
  logic       sclk_prev_q, cs_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q      <= {STAGES{RST_V}};
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      pipe_q[0] <= {cs_ni, sclk_i, mosi_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sclk_prev_q <= st[1];
      cs_prev_q   <= st[2];
    end
  end

  assign st          = pipe_q[STAGES-1];
  assign mosi_o      = st[0];
  assign sclk_rise_o = st[1] & ~sclk_prev_q;
  assign sclk_fall_o = ~st[1] & sclk_prev_q;
  assign cs_act_o    = ~st[2];
  assign cs_end_o    = st[2] & ~cs_prev_q;
endmodule

// File: rtl/spi_id_rx.sv
module spi_id_rx #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             sclk_rise_i,
  input  logic             mosi_i,
  output logic [2:0]       bit_cnt_o,
  output logic             byte_done_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] nbytes_o
);
  localparam logic [CNT_W-1:0] NB_MAX = {CNT_W{1'b1}};

  logic [6:0] sh_q;
  logic       shift_en;

  assign shift_en    = cs_act_i & sclk_rise_i;
  assign byte_done_o = shift_en & (bit_cnt_o == 3'd7);
  assign byte_o      = {sh_q, mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_o <= '0;
      nbytes_o  <= '0;
      sh_q      <= '0;
    end else if (!cs_act_i) begin
      bit_cnt_o <= '0;
      nbytes_o  <= '0;
    end else if (shift_en) begin
      bit_cnt_o <= bit_cnt_o + 3'd1;
      sh_q      <= {sh_q[5:0], mosi_i};
      if (byte_done_o && nbytes_o != NB_MAX) nbytes_o <= nbytes_o + 1'b1;
    end
  end
endmodule

// File: rtl/spi_id_ctrl.sv
module spi_id_ctrl
  import spi_id_pkg::*;
#(
  parameter int         CNT_W    = 3,
  parameter logic [7:0] MFR_ID   = 8'hC2,
  parameter logic [7:0] MEM_TYPE = 8'h20,
  parameter logic [7:0] DEV_ID   = 8'h16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             cs_end_i,
  input  logic             sclk_fall_i,
  input  logic [2:0]       bit_cnt_i,
  input  logic             byte_done_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  output logic [7:0]       status_o
);
  logic [7:0] opcode_q, tx_q;
  logic [7:2] stat_hi_q, wr_data_q;
  logic       wel_q, sel_dev_q;
  resp_t      resp;

  assign status_o = {stat_hi_q, wel_q, 1'b0};
  assign miso_o   = tx_q[7] & miso_oe_o;

  // response for the byte slot about to start (slot 0 = opcode)
  always_comb begin
    resp = '0;
    unique case (opcode_q)
      OP_RDID: begin
        if (nbytes_i == CNT_W'(1)) resp = '{1'b1, MFR_ID};
        if (nbytes_i == CNT_W'(2)) resp = '{1'b1, MEM_TYPE};
        if (nbytes_i == CNT_W'(3)) resp = '{1'b1, DEV_ID};
      end
      OP_REMS: begin
        if (nbytes_i == CNT_W'(4)) resp = '{1'b1, sel_dev_q ? DEV_ID : MFR_ID};
        if (nbytes_i == CNT_W'(5)) resp = '{1'b1, sel_dev_q ? MFR_ID : DEV_ID};
      end
      OP_RES:  if (nbytes_i == CNT_W'(4)) resp = '{1'b1, DEV_ID};
      OP_RDSR: resp = '{1'b1, status_o};
      default: resp = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q  <= '0;
      sel_dev_q <= 1'b0;
      wr_data_q <= '0;
      tx_q      <= '0;
      miso_oe_o <= 1'b0;
    end else if (!cs_act_i) begin
      opcode_q  <= '0;
      sel_dev_q <= 1'b0;
      tx_q      <= '0;
      miso_oe_o <= 1'b0;
    end else begin
      if (byte_done_i) begin
        if (nbytes_i == '0) opcode_q <= byte_i;
        if (opcode_q == OP_REMS && nbytes_i == CNT_W'(3))
          sel_dev_q <= (byte_i == SEL_DEV_FIRST);
        if (opcode_q == OP_WRSR && nbytes_i == CNT_W'(1))
          wr_data_q <= byte_i[7:2];
      end
      if (sclk_fall_i) begin
        if (bit_cnt_i == 3'd0) begin
          if (nbytes_i != '0) begin
            miso_oe_o <= resp.vld;
            tx_q      <= resp.data;
          end
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  // status register: write enable takes effect at opcode end, status write at CS rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_hi_q <= '0;
      wel_q     <= 1'b0;
    end else if (cs_act_i && byte_done_i && nbytes_i == '0) begin
      if (byte_i == OP_WREN) wel_q <= 1'b1;
      if (byte_i == OP_WRDI) wel_q <= 1'b0;
    end else if (cs_end_i && opcode_q == OP_WRSR && bit_cnt_i == 3'd0 && wel_q &&
                 (nbytes_i == CNT_W'(2) || nbytes_i == CNT_W'(3))) begin
      stat_hi_q <= wr_data_q;
      wel_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flash_id_resp.sv
module spi_flash_id_resp #(
  parameter logic [7:0] MFR_ID      = 8'hC2,
  parameter logic [7:0] MEM_TYPE    = 8'h20,
  parameter logic [7:0] DEV_ID      = 8'h16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int CNT_W = 3;

  logic             sclk_rise, sclk_fall, cs_act, cs_end, mosi_s;
  logic [2:0]       bit_cnt;
  logic             byte_done;
  logic [7:0]       byte_v, status;
  logic [CNT_W-1:0] nbytes;

  spi_id_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_act_o(cs_act), .cs_end_o(cs_end), .mosi_o(mosi_s)
  );

  spi_id_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .sclk_rise_i(sclk_rise), .mosi_i(mosi_s),
    .bit_cnt_o(bit_cnt), .byte_done_o(byte_done), .byte_o(byte_v), .nbytes_o(nbytes)
  );

  spi_id_ctrl #(.CNT_W(CNT_W), .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .DEV_ID(DEV_ID)) u_ctrl (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .cs_end_i(cs_end), .sclk_fall_i(sclk_fall),
    .bit_cnt_i(bit_cnt), .byte_done_i(byte_done), .byte_i(byte_v), .nbytes_i(nbytes),
    .miso_o, .miso_oe_o, .status_o(status)
  );
endmodule

// File: rtl/spi_flash_id_resp_chk.sv
module spi_flash_id_resp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_act,
  input logic       sclk_rise,
  input logic       sclk_fall,
  input logic [2:0] bit_cnt,
  input logic [2:0] nbytes,
  input logic       byte_done,
  input logic [7:0] byte_v,
  input logic [7:0] status,
  input logic       miso_o,
  input logic       miso_oe_o
);
  p_idle_undriven_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !miso_oe_o);

  p_opcode_undriven_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> nbytes != 3'd0);

  p_out_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act && !sclk_fall |=> $stable(miso_o) && $stable(miso_oe_o));

  p_bit_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act && sclk_rise && bit_cnt == 3'd7 |=> bit_cnt == 3'd0);

  p_wel_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && nbytes == 3'd0 && byte_v == 8'h06 |=> status[1]);

  p_wel_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && nbytes == 3'd0 && byte_v == 8'h04 |=> !status[1]);

  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> bit_cnt == 3'd0 && nbytes == 3'd0);
endmodule

bind spi_flash_id_resp spi_flash_id_resp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .bit_cnt(bit_cnt), .nbytes(nbytes), .byte_done(byte_done),
  .byte_v(byte_v), .status(status), .miso_o(miso_o), .miso_oe_o(miso_oe_o)
);

// File: tb/sim_spi_flash_id_resp.sv
`timescale 1ns/1ps
module sim_spi_flash_id_resp;
  localparam logic [7:0] MFR  = 8'hC2;
  localparam logic [7:0] TYP  = 8'h20;
  localparam logic [7:0] DEV  = 8'h16;
  localparam int         HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_flash_id_resp #(.MFR_ID(MFR), .MEM_TYPE(TYP), .DEV_ID(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  // shift nbits of tx (MSB first); rx samples miso just before each rising edge
  task automatic xfer_bits(input logic [7:0] tx, input int nbits,
                           output logic [7:0] rx, output bit oe_all, output bit oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx = {rx[6:0], miso};
      oe_all &= miso_oe;
      oe_any |= miso_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output bit oe_all, output bit oe_any);
    xfer_bits(tx, 8, rx, oe_all, oe_any);
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [7:0] r; bit a, y;
    cs_begin(); xfer(8'h05, r, a, y); xfer(8'h00, st, a, y); cs_end();
  endtask

  task automatic one_op(input logic [7:0] op);
    logic [7:0] r; bit a, y;
    cs_begin(); xfer(op, r, a, y); cs_end();
  endtask

  task automatic t_reset();
    logic [7:0] st;
    check(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
    read_status(st);
    check(st == 8'h00, "R1 status after reset", st, 8'h00);
  endtask

  task automatic t_rdid();
    logic [7:0] r; bit a, y;
    cs_begin();
    xfer(8'h9F, r, a, y);
    check(!y, "R10 no drive during 9F opcode", y, 0);
    xfer(8'h00, r, a, y); check(r == MFR && a, "R3 R2 mfr byte", r, MFR);
    xfer(8'h00, r, a, y); check(r == TYP && a, "R3 type byte", r, TYP);
    xfer(8'h00, r, a, y); check(r == DEV && a, "R3 dev byte", r, DEV);
    xfer(8'h00, r, a, y); check(!y, "R3 undriven after ids", y, 0);
    cs_end();
    check(miso_oe == 1'b0, "R10 oe after CS high", miso_oe, 0);
  endtask

  task automatic t_rems(input logic [7:0] sel);
    logic [7:0] r, first, second; bit a, y, dummy_any;
    logic [7:0] e1, e2;
    e1 = (sel == 8'h01) ? DEV : MFR;
    e2 = (sel == 8'h01) ? MFR : DEV;
    cs_begin();
    xfer(8'h90, r, a, y);
    xfer(8'h00, r, a, dummy_any);
    xfer(8'h00, r, a, y); dummy_any |= y;
    xfer(sel, r, a, y);   dummy_any |= y;
    check(!dummy_any, "R4 R10 dummy and selector undriven", dummy_any, 0);
    xfer(8'h00, first, a, y);  check(first == e1 && a, "R4 first id", first, e1);
    xfer(8'h00, second, a, y); check(second == e2 && a, "R4 second id", second, e2);
    cs_end();
  endtask

  task automatic t_res();
    logic [7:0] r; bit a, y, d;
    cs_begin();
    xfer(8'hAB, r, a, d);
    for (int i = 0; i < 3; i++) begin xfer(8'h00, r, a, y); d |= y; end
    check(!d, "R5 dummies undriven", d, 0);
    xfer(8'h00, r, a, y); check(r == DEV && a, "R5 dev id", r, DEV);
    cs_end();
  endtask

  task automatic t_wel_rdsr();
    logic [7:0] r; bit a, y;
    one_op(8'h06);
    cs_begin();
    xfer(8'h05, r, a, y);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r, a, y);
      check(r == 8'h02 && a, "R6 R7 repeated status with WEL", r, 8'h02);
    end
    cs_end();
    one_op(8'h04);
    read_status(r);
    check(r == 8'h00, "R7 WEL cleared by 04", r, 8'h00);
  endtask

  task automatic t_wrsr_ok();
    logic [7:0] r, st; bit a, y;
    one_op(8'h06);
    cs_begin(); xfer(8'h01, r, a, y); xfer(8'hFD, r, a, y); cs_end();
    read_status(st);
    check(st == 8'hFC, "R8 one-byte write, WEL cleared, bit0 zero", st, 8'hFC);
    one_op(8'h06);
    cs_begin(); xfer(8'h01, r, a, y); xfer(8'h54, r, a, y); xfer(8'hFF, r, a, y); cs_end();
    read_status(st);
    check(st == 8'h54, "R8 two-byte write, second ignored", st, 8'h54);
  endtask

  task automatic t_wrsr_discard();
    logic [7:0] r, st; bit a, y;
    one_op(8'h06);
    cs_begin(); xfer(8'h01, r, a, y); xfer(8'h00, r, a, y); xfer_bits(8'h00, 4, r, a, y); cs_end();
    read_status(st);
    check(st == 8'h56, "R9 mid-byte CS rise discards", st, 8'h56);
    cs_begin(); xfer(8'h01, r, a, y);
    for (int i = 0; i < 3; i++) xfer(8'h00, r, a, y);
    cs_end();
    read_status(st);
    check(st == 8'h56, "R9 three data bytes discards", st, 8'h56);
    one_op(8'h04);
    cs_begin(); xfer(8'h01, r, a, y); xfer(8'h00, r, a, y); cs_end();
    read_status(st);
    check(st == 8'h54, "R9 no write without WEL", st, 8'h54);
  endtask

  task automatic t_unknown();
    logic [7:0] r; bit a, y, any;
    any = 1'b0;
    cs_begin();
    xfer(8'h03, r, a, y); any |= y;
    for (int i = 0; i < 6; i++) begin xfer(8'hA5, r, a, y); any |= y; end
    cs_end();
    check(!any, "R10 unanswered opcode never drives", any, 0);
  endtask

  task automatic t_abort();
    logic [7:0] r; bit a, y;
    cs_begin(); xfer_bits(8'h9F, 5, r, a, y); cs_end();
    cs_begin();
    xfer(8'h9F, r, a, y);
    xfer(8'h00, r, a, y); check(r == MFR && a, "R11 fresh opcode after partial", r, MFR);
    xfer_bits(8'h00, 3, r, a, y);
    cs_end();
    check(miso_oe == 1'b0, "R11 R10 oe dropped on abort", miso_oe, 0);
    cs_begin();
    xfer(8'hAB, r, a, y);
    for (int i = 0; i < 3; i++) xfer(8'h00, r, a, y);
    xfer(8'h00, r, a, y); check(r == DEV, "R11 decode after mid-byte abort", r, DEV);
    cs_end();
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_rdid();
    t_rems(8'h00);
    t_rems(8'h01);
    t_rems(8'h05);
    t_res();
    t_wel_rdsr();
    t_wrsr_ok();
    t_wrsr_discard();
    t_unknown();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule